// File: doc/BRIEF.md
# Serial DAC Frame Shifter

This block moves 32-bit control words for an eight-channel, 12-bit digital-to-analog converter from an upstream queue onto a three-wire serial link. A one-entry holding register takes a word whenever the upstream side signals a valid word and the register is empty. The shift engine then drains the register and sends the word most-significant bit first. It uses a serial clock divided down from the system clock, an active-low frame strobe and a data line.

The word can come in ready-made, or the block can build it from three fields: a 4-bit command code, a 4-bit channel address and a 12-bit output code. Commands either update an output or change the converter's operating mode. The converter samples data on the falling edge of the serial clock. Data therefore changes only on rising edges, and the strobe stays low across exactly 32 falling edges per frame.

Top module: `dac_spi_serializer`

## Requirements
- R1: Each accepted word is sent as one 32-bit frame, starting with bit 31 and ending with bit 0, with one bit taken on each falling edge of `dac_sclk` while `dac_nsync` is low.
- R2: `dac_nsync` stays low across exactly 32 falling edges of `dac_sclk` in every frame.
- R3: While `dac_nsync` is low, `dac_din` changes only in the cycle where `dac_sclk` rises or where `dac_nsync` falls, so it is stable at every falling edge.
- R4: Whenever `dac_nsync` is high, `dac_sclk` is high.
- R5: Between two frames `dac_nsync` stays high for at least one full serial clock period (2*HALF_DIV system clocks).
- R6: A word is taken on a rising `clk` edge only when `up_ready` is 1 and `up_full` is 0. `up_full` is 1 from the cycle after the word is taken until the engine drains it.
- R7: While `up_full` is 1, `up_ready` and the message inputs have no effect: the held word is sent unchanged and no extra frame appears.
- R8: With `fmt_sel`=1 the word is built with `fld_cmd` in bits [27:24], `fld_chan` in bits [23:20], `fld_code` in bits [19:8], and zero in bits [31:28] and [7:0]. With `fmt_sel`=0 the word is `up_msg`, and the field inputs are ignored.
- R9: Inside a frame each half period of `dac_sclk`, and the delay from the falling edge of `dac_nsync` to the first falling edge of `dac_sclk`, lasts HALF_DIV system clocks.
- R10: During and right after reset, `dac_nsync`=1, `dac_sclk`=1, `dac_din`=0 and `up_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_ready | input | 1 | Upstream has a word to hand over |
| fmt_sel | input | 1 | 1: build the word from the fields, 0: take up_msg |
| up_msg | input | 32 | Ready-made 32-bit word |
| fld_cmd | input | 4 | Command code field |
| fld_chan | input | 4 | Channel address field |
| fld_code | input | 12 | Output code field |
| up_full | output | 1 | Holding register occupied |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_nsync | output | 1 | Active-low frame strobe |
| dac_din | output | 1 | Serial data, MSB first |

## Verification
The upstream handover and the serial shifting can happen in the same cycles: a second word is offered while the first frame is still being shifted out, and a third is offered the moment the engine drains the register. Words are sent back to back, and stray words are pulsed onto the inputs while the register is occupied. A scoreboard then rebuilds each frame from the falling edges. Any frame that is lost, duplicated or corrupted, or a stray word that gets accepted, shows up as a mismatch against the queue of expected words.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

  localparam int FRAME_W  = 32;
  localparam int CMD_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 12;
  localparam int CMD_LSB  = 24;
  localparam int ADDR_LSB = 20;
  localparam int CODE_LSB = 8;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;

  // Builds a control word from its fields; every unused bit is zero.
  function automatic frame_t pack_frame(input logic [CMD_W-1:0]  cmd,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [CODE_W-1:0] code);
    frame_t f;
    f = '0;
    f[CMD_LSB  +: CMD_W]  = cmd;
    f[ADDR_LSB +: ADDR_W] = addr;
    f[CODE_LSB +: CODE_W] = code;
    return f;
  endfunction

endpackage

// File: rtl/dac_sclk_divider.sv
module dac_sclk_divider #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    half_tick = (cnt_q == LAST);
    cnt_d     = half_tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_spacing
      // R9: two half-period ticks are never adjacent when the divider is above one
      a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
    end
  endgenerate

endmodule

// File: rtl/dac_hold_buf.sv
module dac_hold_buf
  import dac_ser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  frame_t load_data,
  input  logic   drain_en,
  output logic   full,
  output frame_t data
);
  logic   full_q, full_d;
  frame_t data_q;

  always_comb begin
    full_d = full_q;
    if (load_en)       full_d = 1'b1;
    else if (drain_en) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= load_data;
  end

  assign full = full_q;
  assign data = data_q;

  // R6: a load request only reaches an empty register
  a_r6_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !full_q);

  // R7: an occupied register keeps its word until the engine drains it
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !drain_en) |=> (full_q && $stable(data_q)));

  // R6: a drain only happens on an occupied register
  a_r6_drain_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    drain_en |-> full_q);

endmodule

// File: rtl/dac_shift_engine.sv
module dac_shift_engine
  import dac_ser_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   half_tick,
  input  logic   buf_full,
  input  frame_t buf_data,
  output logic   drain,
  output logic   sclk,
  output logic   nsync,
  output logic   din
);
  localparam int BIT_W      = $clog2(FRAME_W);
  localparam int GAP_HALVES = 2;
  localparam int GAP_W      = $clog2(GAP_HALVES);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_HALVES - 1);

  eng_state_e       state_q, state_d;
  frame_t           sh_q, sh_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             sclk_q, sclk_d;
  logic             nsync_q, nsync_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    gap_d   = gap_q;
    sclk_d  = sclk_q;
    nsync_d = nsync_q;
    drain   = (state_q == ENG_IDLE) && half_tick && buf_full;
    unique case (state_q)
      ENG_IDLE: begin
        if (drain) begin
          sh_d    = buf_data;
          bit_d   = '0;
          nsync_d = 1'b0;
          state_d = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (half_tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else begin
            sclk_d = 1'b1;
            if (bit_q == LAST_BIT) begin
              nsync_d = 1'b1;
              gap_d   = '0;
              state_d = ENG_GAP;
            end else begin
              sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
              bit_d = bit_q + BIT_W'(1);
            end
          end
        end
      end
      ENG_GAP: begin
        if (half_tick) begin
          if (gap_q == LAST_GAP) state_d = ENG_IDLE;
          else                   gap_d   = gap_q + GAP_W'(1);
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      sclk_q  <= 1'b1;
      nsync_q <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      gap_q   <= gap_d;
      sclk_q  <= sclk_d;
      nsync_q <= nsync_d;
    end
  end

  assign sclk  = sclk_q;
  assign nsync = nsync_q;
  assign din   = sh_q[FRAME_W-1];

  // Observation counters for the frame-shape properties below
  logic [BIT_W:0] chk_falls_q;
  logic [31:0]    chk_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chk_falls_q <= '0;
    else if ($fell(nsync_q))
      chk_falls_q <= '0;
    else if (!nsync_q && sclk_q && !sclk_d)
      chk_falls_q <= chk_falls_q + (BIT_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chk_hi_q <= 32'(2 * HALF_DIV);
    else if (!nsync_q)          chk_hi_q <= '0;
    else if (chk_hi_q != '1)    chk_hi_q <= chk_hi_q + 32'd1;
  end

  // R2: exactly one frame's worth of falling edges before the strobe releases
  a_r2_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nsync_q) |-> (chk_falls_q == (BIT_W+1)'(FRAME_W)));

  // R3: data moves only with a rising serial clock or the start of a frame
  a_r3_din_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(din) && !nsync_q) |-> ($rose(sclk_q) || $fell(nsync_q)));

  // R4: serial clock parked high outside a frame
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    nsync_q |-> sclk_q);

  // R5: minimum strobe-high time between frames
  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nsync_q) |-> (chk_hi_q >= 32'(2 * HALF_DIV)));

endmodule

// File: rtl/dac_spi_serializer.sv
module dac_spi_serializer
  import dac_ser_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_ready,
  input  logic              fmt_sel,
  input  logic [FRAME_W-1:0] up_msg,
  input  logic [CMD_W-1:0]  fld_cmd,
  input  logic [ADDR_W-1:0] fld_chan,
  input  logic [CODE_W-1:0] fld_code,
  output logic              up_full,
  output logic              dac_sclk,
  output logic              dac_nsync,
  output logic              dac_din
);
  logic   half_tick;
  logic   load_en;
  logic   drain;
  logic   buf_full;
  frame_t buf_data;
  frame_t in_word;

  always_comb begin
    in_word = fmt_sel ? pack_frame(fld_cmd, fld_chan, fld_code) : up_msg;
    load_en = up_ready && !buf_full;
  end

  dac_sclk_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick)
  );

  dac_hold_buf u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (in_word),
    .drain_en  (drain),
    .full      (buf_full),
    .data      (buf_data)
  );

  dac_shift_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .drain     (drain),
    .sclk      (dac_sclk),
    .nsync     (dac_nsync),
    .din       (dac_din)
  );

  assign up_full = buf_full;

  // R6: an offered word while empty shows up as occupied one cycle later
  a_r6_full_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && !up_full) |=> up_full);

endmodule

// File: tb/tb_dac_spi_serializer.sv
module tb_dac_spi_serializer;
  localparam int HALF_DIV = 3;
  localparam int WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        up_ready;
  logic        fmt_sel;
  logic [31:0] up_msg;
  logic [3:0]  fld_cmd;
  logic [3:0]  fld_chan;
  logic [11:0] fld_code;
  logic        up_full, dac_sclk, dac_nsync, dac_din;

  dac_spi_serializer #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .fmt_sel(fmt_sel),
    .up_msg(up_msg), .fld_cmd(fld_cmd), .fld_chan(fld_chan), .fld_code(fld_code),
    .up_full(up_full), .dac_sclk(dac_sclk), .dac_nsync(dac_nsync), .dac_din(dac_din)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Watchdog
  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt == WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd_cnt, WD_LIMIT);
      finish_run();
    end
  end

  // Monitor: rebuilds frames on serial falling edges and compares with the scoreboard
  logic        p_sclk = 1'b1, p_nsync = 1'b1, p_din = 1'b0;
  logic [31:0] cap = '0;
  int          falls = 0;
  int          hi_cyc = 0;
  int          half_cyc = 0;
  bit          seen_frame = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_nsync && !dac_sclk)
        chk(1'b0, "R4 sclk low while strobe high", {31'd0, dac_sclk}, 32'd1);
      if (!p_nsync && !dac_nsync && (dac_din != p_din) && !(dac_sclk && !p_sclk))
        chk(1'b0, "R3 din moved off rising edge", {31'd0, dac_din}, {31'd0, p_din});
      if (p_nsync && !dac_nsync) begin
        if (seen_frame)
          chk(hi_cyc >= 2*HALF_DIV, "R5 strobe gap", 32'(hi_cyc), 32'(2*HALF_DIV));
        falls = 0; cap = '0; half_cyc = 1;
      end else if (!p_nsync) begin
        if (dac_sclk != p_sclk) begin
          chk(half_cyc == HALF_DIV, "R9 half period", 32'(half_cyc), 32'(HALF_DIV));
          half_cyc = 1;
        end else begin
          half_cyc++;
        end
        if (p_sclk && !dac_sclk && !dac_nsync) begin
          cap = {cap[30:0], dac_din};
          falls++;
        end
      end
      if (!p_nsync && dac_nsync) begin
        seen_frame = 1'b1;
        chk(falls == 32, "R2 falling edges per frame", 32'(falls), 32'd32);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected extra frame", cap, 32'hxxxxxxxx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cap == e, t, cap, e);
        end
        hi_cyc = 1;
      end else if (dac_nsync) begin
        hi_cyc++;
      end
      p_sclk = dac_sclk; p_nsync = dac_nsync; p_din = dac_din;
    end
  end

  // Driver tasks
  task automatic offer(input logic [31:0] expw, input string tag);
    @(negedge clk);
    while (up_full) @(negedge clk);
    up_ready = 1'b1;
    exp_q.push_back(expw);
    tag_q.push_back(tag);
    @(negedge clk);
    up_ready = 1'b0;
    chk(up_full == 1'b1, "R6 full after take", {31'd0, up_full}, 32'd1);
  endtask

  task automatic send_raw(input logic [31:0] w);
    fmt_sel  = 1'b0;
    up_msg   = w;
    fld_cmd  = ~w[3:0];
    fld_chan = ~w[7:4];
    fld_code = ~w[19:8];
    offer(w, "R1 raw frame content");
  endtask

  task automatic send_pack(input logic [3:0] c, input logic [3:0] a, input logic [11:0] d);
    fmt_sel  = 1'b1;
    up_msg   = 32'hFFFF_FFFF;
    fld_cmd  = c;
    fld_chan = a;
    fld_code = d;
    offer({4'h0, c, a, d, 8'h00}, "R8 packed frame content");
  endtask

  // Pulses a stray word while the register is occupied; it must never be sent
  task automatic poke_while_full();
    @(negedge clk);
    while (!up_full) @(negedge clk);
    fmt_sel  = 1'b0;
    up_msg   = 32'hDEAD_BEEF;
    up_ready = 1'b1;
    @(negedge clk);
    up_ready = 1'b0;
  endtask

  initial begin
    rst_n    = 1'b0;
    up_ready = 1'b0;
    fmt_sel  = 1'b0;
    up_msg   = '0;
    fld_cmd  = '0;
    fld_chan = '0;
    fld_code = '0;
    repeat (3) @(negedge clk);
    chk(dac_nsync == 1'b1, "R10 reset strobe", {31'd0, dac_nsync}, 32'd1);
    chk(dac_sclk  == 1'b1, "R10 reset sclk",   {31'd0, dac_sclk},  32'd1);
    chk(dac_din   == 1'b0, "R10 reset din",    {31'd0, dac_din},   32'd0);
    chk(up_full   == 1'b0, "R10 reset full",   {31'd0, up_full},   32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_nsync == 1'b1 && dac_sclk == 1'b1 && up_full == 1'b0, "R10 after release",
        {29'd0, dac_nsync, dac_sclk, up_full}, 32'd6);

    send_raw(32'hA5C3_0F81);
    send_raw(32'h8000_0001);
    poke_while_full();
    send_pack(4'h3, 4'h0, 12'hFFF);
    poke_while_full();
    send_pack(4'hF, 4'h7, 12'h001);
    send_raw(32'hFFFF_FFFF);
    send_raw(32'h0000_0000);
    send_pack(4'h8, 4'h5, 12'hABC);
    send_raw(32'h1234_5678);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (8 * HALF_DIV) @(negedge clk);
    chk(dac_nsync == 1'b1 && dac_sclk == 1'b1, "R7 no stray frame after queue drained",
        {30'd0, dac_nsync, dac_sclk}, 32'd3);
    chk(up_full == 1'b0, "R6 register empty at end", {31'd0, up_full}, 32'd0);
    finish_run();
  end

endmodule